// File: doc/BRIEF.md
# External Interrupt Edge Detector

This block turns a set of external interrupt pins into interrupt requests for a processor core. Each channel first synchronizes its pin. It then compares the current synchronized sample with the previous one and applies a per-channel trigger selection. The result drives two flags that are set and cleared independently.

The edge flag is meant for software. It records that an active transition was seen, and only a software write clears it. The request flag is what the core polls, or uses to take the interrupt vector. It is set on every active event and clears when the core acknowledges that channel.

A small write port carries two things: the trigger selections, and write-one-to-clear commands for either flag. Arbitration between channels, the core itself and the vector table sit outside the block.

Top module: `extint_edge_unit`

## Requirements
- R1: After reset both flags of every channel read 0, and every channel's trigger selection is falling edge (code 00), so a falling pin sets flags without any prior mode write.
- R2: With trigger code 00 (falling), a high-to-low transition of the synchronized pin sets both flags of that channel, and a low-to-high transition sets neither.
- R3: With trigger code 01 (rising), a low-to-high transition sets both flags, and a high-to-low transition sets neither.
- R4: With trigger code 10 (both), each transition in either direction sets both flags.
- R5: With trigger code 11 (bypass), the request flag is set in every cycle the synchronized pin is low, so an acknowledge does not clear it while the pin stays low. The edge flag is set only on the high-to-low transition.
- R6: In bypass mode, clearing the edge flag while the pin is held low does not set the edge flag again.
- R7: A one-cycle pulse on a channel's acknowledge input clears that channel's request flag and leaves its edge flag unchanged.
- R8: Writing with address 1 clears edge flag c where data bit c is 1, and request flag c where data bit NUM_CH+c is 1. Clearing one flag of a channel leaves the other flag unchanged.
- R9: When a flag's set event and its clear (a software write or an acknowledge) fall in the same cycle, the flag ends up set. A write to the flag register therefore never drops an incoming event.
- R10: Writing with address 0 loads channel c's trigger code from data bits [2c+1:2c]. Events on one channel never change another channel's flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_CH | External interrupt pins, asynchronous, idle high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects trigger codes, 1 selects flag clears |
| wr_data | input | 2*NUM_CH | Write data: trigger codes or clear bits |
| ack_i | input | NUM_CH | Per-channel vector acknowledge from the core |
| req_o | output | NUM_CH | Request flags |
| edge_flag_o | output | NUM_CH | Edge flags for software readback |

## Verification
The assertions assume two things: reset is held from the first clock edge, and every input is a known value at each rising edge. An acknowledge and a write are taken to last exactly one cycle each.

The bench changes inputs only on falling clock edges. It holds each pin level for at least four cycles, so every transition passes through the synchronizer before the next one arrives. For the collision case it places the clear write in exactly the cycle in which the detected event reaches the flag.

// File: rtl/extint_pkg.sv
package extint_pkg;
  typedef enum logic [1:0] {
    TRIG_FALL  = 2'b00,
    TRIG_RISE  = 2'b01,
    TRIG_BOTH  = 2'b10,
    TRIG_LEVEL = 2'b11
  } trig_e;

  localparam logic ADDR_MODE = 1'b0;
  localparam logic ADDR_CLR  = 1'b1;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= {STAGES{RST_VAL}};
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/extint_event_detect.sv
module extint_event_detect
  import extint_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  pin_s,
  input  trig_e mode,
  output logic  edge_evt,
  output logic  req_evt
);
  logic prev_q;
  logic fall, rise;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= pin_s;
  end

  assign fall = prev_q & ~pin_s;
  assign rise = ~prev_q & pin_s;

  always_comb begin
    case (mode)
      TRIG_FALL:  begin edge_evt = fall;        req_evt = fall;   end
      TRIG_RISE:  begin edge_evt = rise;        req_evt = rise;   end
      TRIG_BOTH:  begin edge_evt = fall | rise; req_evt = fall | rise; end
      default:    begin edge_evt = fall;        req_evt = ~pin_s; end
    endcase
  end
endmodule

// File: rtl/extint_flag_cell.sv
module extint_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/extint_edge_unit.sv
module extint_edge_unit
  import extint_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_CH-1:0]   pin_i,
  input  logic                wr_en,
  input  logic                wr_addr,
  input  logic [2*NUM_CH-1:0] wr_data,
  input  logic [NUM_CH-1:0]   ack_i,
  output logic [NUM_CH-1:0]   req_o,
  output logic [NUM_CH-1:0]   edge_flag_o
);
  localparam int DW = 2 * NUM_CH;

  logic              mode_wr, clr_wr;
  trig_e             mode_q [NUM_CH];
  logic [NUM_CH-1:0] pin_s;
  logic [NUM_CH-1:0] edge_set, req_set;
  logic [NUM_CH-1:0] edge_clr, req_clr;

  assign mode_wr = wr_en && (wr_addr == ADDR_MODE);
  assign clr_wr  = wr_en && (wr_addr == ADDR_CLR);

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_CH; i++) begin
      if (rst)          mode_q[i] <= TRIG_FALL;
      else if (mode_wr) mode_q[i] <= trig_e'(wr_data[2*i +: 2]);
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    extint_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk (clk), .rst (rst), .d (pin_i[c]), .q (pin_s[c])
    );

    extint_event_detect u_det (
      .clk (clk), .rst (rst), .pin_s (pin_s[c]), .mode (mode_q[c]),
      .edge_evt (edge_set[c]), .req_evt (req_set[c])
    );

    assign edge_clr[c] = clr_wr & wr_data[c];
    assign req_clr[c]  = (clr_wr & wr_data[NUM_CH + c]) | ack_i[c];

    extint_flag_cell u_edge_flag (
      .clk (clk), .rst (rst), .set (edge_set[c]), .clr (edge_clr[c]),
      .q (edge_flag_o[c])
    );

    extint_flag_cell u_req_flag (
      .clk (clk), .rst (rst), .set (req_set[c]), .clr (req_clr[c]),
      .q (req_o[c])
    );
  end

  if (DW < 2) begin : g_bad_cfg
    initial $error("NUM_CH must be at least 1");
  end
endmodule

// File: rtl/extint_edge_unit_chk.sv
module extint_edge_unit_chk #(
  parameter int NUM_CH = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic                wr_addr,
  input logic [2*NUM_CH-1:0] wr_data,
  input logic [NUM_CH-1:0]   ack_i,
  input logic [NUM_CH-1:0]   edge_set,
  input logic [NUM_CH-1:0]   req_set,
  input logic [NUM_CH-1:0]   req_o,
  input logic [NUM_CH-1:0]   edge_flag_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R9
    edge_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      edge_set[c] |=> edge_flag_o[c]);

    // R9
    req_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      req_set[c] |=> req_o[c]);

    // R2
    edge_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(edge_flag_o[c]) |-> $past(edge_set[c]));

    // R8
    edge_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(edge_flag_o[c]) |-> $past(wr_en && wr_addr && wr_data[c]));

    // R7
    req_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(req_o[c]) |-> $past(ack_i[c] || (wr_en && wr_addr && wr_data[NUM_CH + c])));
  end
endmodule

bind extint_edge_unit extint_edge_unit_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk (clk), .rst (rst), .wr_en (wr_en), .wr_addr (wr_addr),
  .wr_data (wr_data), .ack_i (ack_i), .edge_set (edge_set),
  .req_set (req_set), .req_o (req_o), .edge_flag_o (edge_flag_o)
);

// File: tb/sim_extint_edge_unit.sv
module sim_extint_edge_unit;
  localparam int NUM_CH = 2;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [NUM_CH-1:0]   pin_i = '1;
  logic                wr_en = 1'b0;
  logic                wr_addr = 1'b0;
  logic [2*NUM_CH-1:0] wr_data = '0;
  logic [NUM_CH-1:0]   ack_i = '0;
  logic [NUM_CH-1:0]   req_o, edge_flag_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  extint_edge_unit #(.NUM_CH(NUM_CH), .SYNC_STAGES(2)) u0 (
    .clk (clk), .rst (rst), .pin_i (pin_i), .wr_en (wr_en),
    .wr_addr (wr_addr), .wr_data (wr_data), .ack_i (ack_i),
    .req_o (req_o), .edge_flag_o (edge_flag_o)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_reg(logic a, logic [2*NUM_CH-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse_ack(logic [NUM_CH-1:0] m);
    ack_i = m;
    @(negedge clk);
    ack_i = '0;
  endtask

  task automatic set_pin(int c, logic v);
    pin_i[c] = v;
    wait_cyc(4);
  endtask

  task automatic t_reset();
    check("R1", "req after reset", int'(req_o), 0);
    check("R1", "edge after reset", int'(edge_flag_o), 0);
    set_pin(0, 1'b0);
    check("R1", "default falling mode edge", int'(edge_flag_o), 1);
    check("R1", "default falling mode req", int'(req_o), 1);
    set_pin(0, 1'b1);
    write_reg(1'b1, 4'hF);
  endtask

  task automatic t_falling();
    write_reg(1'b0, 4'b0000);
    set_pin(0, 1'b0);
    check("R2", "edge on fall", int'(edge_flag_o), 1);
    check("R2", "req on fall", int'(req_o), 1);
    check("R10", "other channel untouched", int'(req_o[1]), 0);
    write_reg(1'b1, 4'hF);
    set_pin(0, 1'b1);
    check("R2", "no flags on rise", int'({req_o, edge_flag_o}), 0);
  endtask

  task automatic t_rising();
    write_reg(1'b0, 4'b0001);
    set_pin(0, 1'b0);
    check("R3", "no flags on fall", int'({req_o, edge_flag_o}), 0);
    set_pin(0, 1'b1);
    check("R3", "edge on rise", int'(edge_flag_o), 1);
    check("R3", "req on rise", int'(req_o), 1);
    write_reg(1'b1, 4'hF);
  endtask

  task automatic t_both();
    write_reg(1'b0, 4'b0010);
    set_pin(0, 1'b0);
    check("R4", "flags on fall", int'({req_o, edge_flag_o}), 'h5);
    write_reg(1'b1, 4'hF);
    set_pin(0, 1'b1);
    check("R4", "flags on rise", int'({req_o, edge_flag_o}), 'h5);
    write_reg(1'b1, 4'hF);
  endtask

  task automatic t_ack_and_clear();
    write_reg(1'b0, 4'b0000);
    set_pin(0, 1'b0);
    pulse_ack(2'b01);
    check("R7", "ack clears req", int'(req_o), 0);
    check("R7", "ack keeps edge", int'(edge_flag_o), 1);
    write_reg(1'b1, 4'h1);
    check("R8", "edge cleared", int'(edge_flag_o), 0);
    check("R8", "req unchanged by edge clear", int'(req_o), 0);
    set_pin(0, 1'b1);
    set_pin(0, 1'b0);
    write_reg(1'b1, 4'h4);
    check("R8", "req cleared", int'(req_o), 0);
    check("R8", "edge kept on req clear", int'(edge_flag_o), 1);
    write_reg(1'b1, 4'hF);
    set_pin(0, 1'b1);
  endtask

  task automatic t_bypass();
    write_reg(1'b0, 4'b0011);
    wait_cyc(3);
    check("R5", "pin high no flags", int'({req_o, edge_flag_o}), 0);
    set_pin(0, 1'b0);
    check("R5", "fall sets both", int'({req_o, edge_flag_o}), 'h5);
    write_reg(1'b1, 4'h1);
    wait_cyc(4);
    check("R6", "edge stays clear while low", int'(edge_flag_o), 0);
    check("R6", "req held while low", int'(req_o), 1);
    pulse_ack(2'b01);
    wait_cyc(1);
    check("R5", "level keeps req after ack", int'(req_o), 1);
    set_pin(0, 1'b1);
    pulse_ack(2'b01);
    wait_cyc(2);
    check("R5", "req clear after pin high", int'(req_o), 0);
    check("R5", "no edge on rise", int'(edge_flag_o), 0);
    write_reg(1'b0, 4'b0000);
  endtask

  task automatic t_collide();
    write_reg(1'b1, 4'hF);
    pin_i[0] = 1'b0;
    wait_cyc(2);
    write_reg(1'b1, 4'hF);
    check("R9", "edge set beats clear", int'(edge_flag_o), 1);
    check("R9", "req set beats clear", int'(req_o), 1);
    write_reg(1'b1, 4'hF);
    set_pin(0, 1'b1);
    pin_i[0] = 1'b0;
    wait_cyc(2);
    pulse_ack(2'b01);
    check("R9", "req set beats ack", int'(req_o), 1);
    write_reg(1'b1, 4'hF);
    set_pin(0, 1'b1);
  endtask

  task automatic t_channel();
    write_reg(1'b0, 4'b0100);
    set_pin(1, 1'b0);
    check("R10", "ch1 rising ignores fall", int'({req_o, edge_flag_o}), 0);
    set_pin(1, 1'b1);
    check("R10", "ch1 edge on rise", int'(edge_flag_o), 2);
    check("R10", "ch1 req on rise", int'(req_o), 2);
    set_pin(0, 1'b0);
    check("R10", "ch0 falling set independently", int'(edge_flag_o), 3);
    write_reg(1'b1, 4'b0101);
    check("R10", "per-channel clear", int'({req_o, edge_flag_o}), 'hA);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(1);
    t_reset();
    t_falling();
    t_rising();
    t_both();
    t_ack_and_clear();
    t_bypass();
    t_collide();
    t_channel();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule